// File: doc/BRIEF.md
# Next Instruction Address Unit

This block holds the program counter of a 32-bit fetch stage and works out, every clock cycle, which instruction address comes next. A decoder outside the block supplies a flow class for the instruction at the current address together with its fields. The fields are a 16-bit signed branch displacement, a 26-bit jump field and a 32-bit register operand. A comparator outside the block supplies the branch outcome. The block offers the candidate address on a combinational output and loads it into the program counter at the next rising edge.

A subroutine call with link asks the register file to store the return address in register 31. The return address is the address of the instruction after the call. The request is a single-cycle write strobe that comes with its data and index. A register jump whose operand is not word-aligned raises an error flag. The block has no valid/ready stream: the program counter moves on every cycle, so there is no back-pressure to honour. The control and status pins are plain levels.

Flow class encoding on `flow_i`: 0 sequential, 1 conditional branch, 2 direct jump, 3 call with link, 4 register jump. The codes 5, 6 and 7 are treated as sequential.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter loads the parameter `RESET_VEC` (default 0xBFC00000), and `link_we_o` and `align_err_o` read 0 after that edge.
- R2: For flow code 0 and for the unused codes 5, 6 and 7, the next address is the current address plus 4, modulo 2^32, whatever `taken_i` is.
- R3: For flow code 1 with `taken_i` high, the next address is (current address + 4) plus the 16-bit displacement after sign extension to 32 bits and a left shift by two. Negative displacements move backwards.
- R4: For flow code 1 with `taken_i` low, the next address is the current address plus 4.
- R5: For flow code 2, the next address is bits 31:28 of the current address, followed by the 26-bit jump field, followed by two zero bits.
- R6: For flow code 3, the next address is formed as in R5. In the cycle after that edge, `link_we_o` is 1, `link_idx_o` is 31 and `link_data_o` is the current address plus 4.
- R7: `link_we_o` is high only in the cycle after an edge that consumed flow code 3, and in every other cycle it is low.
- R8: For flow code 4, the next address is the 32-bit register operand, copied unchanged.
- R9: `align_err_o` is high for the cycle after an edge that consumed flow code 4 with operand bits 1:0 not both zero, and it is low in every other cycle.
- R10: `next_pc_o` shows, during a cycle, exactly the address that `pc_o` takes at the following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flow_i | input | 3 | Flow class of the instruction at `pc_o` |
| taken_i | input | 1 | Branch outcome; used only for flow code 1 |
| br_disp_i | input | 16 | Signed branch displacement, counted in words |
| jmp_field_i | input | 26 | Jump field, counted in words |
| reg_opnd_i | input | 32 | Register operand for register jumps |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Address to be loaded at the next edge |
| link_we_o | output | 1 | Write strobe for the return address |
| link_idx_o | output | 5 | Destination register index of the link write (31) |
| link_data_o | output | 32 | Return address |
| align_err_o | output | 1 | Misaligned register-jump target |

## Verification
`next_pc_o` is combinational, so it is due in the same cycle as the inputs. The bench checks it 1 ns after driving, before the rising edge. `pc_o`, the link triple and `align_err_o` are registered, so each is due one edge after the stimulus. The bench drives on the falling edge, lets one rising edge pass, and compares those outputs at the next falling edge with a behavioural model that has been advanced once. Directed steps cover negative displacements, a call whose return address lies in another 256 MiB region than its target, address wrap-around and misaligned operands. A random run then compares the outputs on every cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    FL_SEQ    = 3'd0,
    FL_BRANCH = 3'd1,
    FL_JUMP   = 3'd2,
    FL_CALL   = 3'd3,
    FL_REGJ   = 3'd4
  } flow_e;

  localparam int unsigned FLOW_W = 3;
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STEP   = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  assign addr_o = addr_i + STEP_V;
endmodule

// File: rtl/npc_branch_calc.sv
module npc_branch_calc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 16,
  parameter int unsigned SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] tgt_o
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] disp_bytes;

  assign disp_ext   = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign disp_bytes = disp_ext << SHIFT;
  assign tgt_o      = base_i + disp_bytes;
endmodule

// File: rtl/npc_region_jump.sv
module npc_region_jump #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned FIELD_W = 26,
  parameter int unsigned SHIFT  = 2
) (
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic [ADDR_W-1:0]  tgt_o
);
  localparam int unsigned REGION_W = ADDR_W - FIELD_W - SHIFT;

  logic [ADDR_W-REGION_W-1:0] unused_low;

  assign unused_low = pc_i[ADDR_W-REGION_W-1:0];
  assign tgt_o = {pc_i[ADDR_W-1 -: REGION_W], field_i, {SHIFT{1'b0}}};

  // keep the low bits visibly consumed without feeding logic
  logic unused_ok;
  assign unused_ok = ^unused_low;
endmodule

// File: rtl/npc_target_sel.sv
module npc_target_sel
  import npc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ALIGN_B = 2
) (
  input  logic [FLOW_W-1:0]  flow_i,
  input  logic               taken_i,
  input  logic [ADDR_W-1:0]  seq_i,
  input  logic [ADDR_W-1:0]  br_tgt_i,
  input  logic [ADDR_W-1:0]  jmp_tgt_i,
  input  logic [ADDR_W-1:0]  reg_tgt_i,
  output logic [ADDR_W-1:0]  next_o,
  output logic               call_o,
  output logic               misalign_o
);
  always_comb begin
    next_o     = seq_i;
    call_o     = 1'b0;
    misalign_o = 1'b0;
    case (flow_i)
      FL_BRANCH: next_o = taken_i ? br_tgt_i : seq_i;
      FL_JUMP:   next_o = jmp_tgt_i;
      FL_CALL: begin
        next_o = jmp_tgt_i;
        call_o = 1'b1;
      end
      FL_REGJ: begin
        next_o     = reg_tgt_i;
        misalign_o = |reg_tgt_i[ALIGN_B-1:0];
      end
      default:   next_o = seq_i;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned    ADDR_W    = 32,
  parameter int unsigned    DISP_W    = 16,
  parameter int unsigned    FIELD_W   = 26,
  parameter int unsigned    IDX_W     = 5,
  parameter int unsigned    LINK_REG  = 31,
  parameter logic [31:0]    RESET_VEC = 32'hBFC0_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         flow_i,
  input  logic               taken_i,
  input  logic [DISP_W-1:0]  br_disp_i,
  input  logic [FIELD_W-1:0] jmp_field_i,
  input  logic [ADDR_W-1:0]  reg_opnd_i,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [ADDR_W-1:0]  next_pc_o,
  output logic               link_we_o,
  output logic [IDX_W-1:0]   link_idx_o,
  output logic [ADDR_W-1:0]  link_data_o,
  output logic               align_err_o
);
  localparam int unsigned ALIGN_B = 2;
  localparam int unsigned WORD_B  = 1 << ALIGN_B;
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(WORD_B);
  localparam logic [IDX_W-1:0]  LINK_IDX = IDX_W'(LINK_REG);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_seq;
  logic [ADDR_W-1:0] br_tgt;
  logic [ADDR_W-1:0] jmp_tgt;
  logic [ADDR_W-1:0] next_pc;
  logic              call_req;
  logic              misalign;
  logic              link_we_q;
  logic [IDX_W-1:0]  link_idx_q;
  logic [ADDR_W-1:0] link_data_q;
  logic              align_q;

  npc_incr #(.ADDR_W(ADDR_W), .STEP(WORD_B)) u_incr (
    .addr_i (pc_q),
    .addr_o (pc_seq)
  );

  npc_branch_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SHIFT(ALIGN_B)) u_branch (
    .base_i (pc_seq),
    .disp_i (br_disp_i),
    .tgt_o  (br_tgt)
  );

  npc_region_jump #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .SHIFT(ALIGN_B)) u_jump (
    .pc_i    (pc_q),
    .field_i (jmp_field_i),
    .tgt_o   (jmp_tgt)
  );

  npc_target_sel #(.ADDR_W(ADDR_W), .ALIGN_B(ALIGN_B)) u_sel (
    .flow_i     (flow_i),
    .taken_i    (taken_i),
    .seq_i      (pc_seq),
    .br_tgt_i   (br_tgt),
    .jmp_tgt_i  (jmp_tgt),
    .reg_tgt_i  (reg_opnd_i),
    .next_o     (next_pc),
    .call_o     (call_req),
    .misalign_o (misalign)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= ADDR_W'(RESET_VEC);
      link_we_q   <= 1'b0;
      link_idx_q  <= '0;
      link_data_q <= '0;
      align_q     <= 1'b0;
    end else begin
      pc_q        <= next_pc;
      link_we_q   <= call_req;
      link_idx_q  <= call_req ? LINK_IDX : '0;
      link_data_q <= call_req ? pc_seq : '0;
      align_q     <= misalign;
    end
  end

  assign pc_o        = pc_q;
  assign next_pc_o   = next_pc;
  assign link_we_o   = link_we_q;
  assign link_idx_o  = link_idx_q;
  assign link_data_o = link_data_q;
  assign align_err_o = align_q;

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (flow_i == FL_SEQ) |=> (pc_q == $past(pc_q) + STEP_V)); // R2

  AST_NOT_TAKEN_STEP: assert property (@(posedge clk) disable iff (rst)
    (flow_i == FL_BRANCH && !taken_i) |=> (pc_q == $past(pc_q) + STEP_V)); // R4

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    (flow_i == FL_JUMP || flow_i == FL_CALL) |=>
      (pc_q[ADDR_W-1 -: 4] == $past(pc_q[ADDR_W-1 -: 4]) && pc_q[1:0] == 2'b00)); // R5

  AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (rst)
    link_we_q |-> ($past(flow_i) == FL_CALL)); // R7

  AST_LINK_RETURN: assert property (@(posedge clk) disable iff (rst)
    (flow_i == FL_CALL) |=> (link_we_q && link_idx_q == LINK_IDX &&
                             link_data_q == $past(pc_q) + STEP_V)); // R6

  AST_REGJ_COPY: assert property (@(posedge clk) disable iff (rst)
    (flow_i == FL_REGJ) |=> (pc_q == $past(reg_opnd_i))); // R8

  AST_ALIGN_ONLY_REGJ: assert property (@(posedge clk) disable iff (rst)
    align_q |-> ($past(flow_i) == FL_REGJ && $past(reg_opnd_i[1:0]) != 2'b00)); // R9

  AST_NEXT_LOADED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pc_q == $past(next_pc_o))); // R10
endmodule

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;
  localparam logic [31:0] RVEC = 32'hBFC0_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  flow = 3'd0;
  logic        taken = 1'b0;
  logic [15:0] disp = 16'd0;
  logic [25:0] jf = 26'd0;
  logic [31:0] opnd = 32'd0;
  logic [31:0] pc_o, next_pc_o, link_data_o;
  logic        link_we_o, align_err_o;
  logic [4:0]  link_idx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_pc;
  logic        m_we;
  logic [31:0] m_ldata;
  logic        m_aerr;

  always #10 clk = ~clk;

  npc_unit #(.RESET_VEC(RVEC)) i_npc_unit (
    .clk(clk), .rst(rst), .flow_i(flow), .taken_i(taken),
    .br_disp_i(disp), .jmp_field_i(jf), .reg_opnd_i(opnd),
    .pc_o(pc_o), .next_pc_o(next_pc_o), .link_we_o(link_we_o),
    .link_idx_o(link_idx_o), .link_data_o(link_data_o),
    .align_err_o(align_err_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] pc, input int f,
      input bit tk, input logic [15:0] d, input logic [25:0] j, input logic [31:0] r);
    int signed dw;
    logic [31:0] res;
    dw = $signed(d);
    case (f)
      1: res = tk ? pc + 32'd4 + 32'(dw * 4) : pc + 32'd4;
      2, 3: res = (pc & 32'hF000_0000) | (32'(j) * 32'd4);
      4: res = r;
      default: res = pc + 32'd4;
    endcase
    return res;
  endfunction

  // one cycle: called just after a falling edge
  task automatic step(input int f, input bit tk, input logic [15:0] d,
                      input logic [25:0] j, input logic [31:0] r, input string tag);
    logic [31:0] exp_n;
    flow = 3'(f); taken = tk; disp = d; jf = j; opnd = r;
    exp_n = model_next(m_pc, f, tk, d, j, r);
    #1;
    chk({"R10 next_pc ", tag}, next_pc_o, exp_n);
    @(posedge clk);
    m_we    = (f == 3);
    m_ldata = m_pc + 32'd4;
    m_aerr  = (f == 4) && (r[1:0] != 2'b00);
    m_pc    = exp_n;
    @(negedge clk);
    chk({tag, " pc"}, pc_o, m_pc);
    chk({"R7 link_we ", tag}, 32'(link_we_o), 32'(m_we));
    if (m_we) begin
      chk({"R6 link_idx ", tag}, 32'(link_idx_o), 32'd31);
      chk({"R6 link_data ", tag}, link_data_o, m_ldata);
    end
    chk({"R9 align_err ", tag}, 32'(align_err_o), 32'(m_aerr));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pc", pc_o, RVEC);
    chk("R1 reset link_we", 32'(link_we_o), 32'd0);
    chk("R1 reset align_err", 32'(align_err_o), 32'd0);
    rst = 1'b0;
    m_pc = RVEC;

    step(0, 1'b1, 16'h0000, 26'h0, 32'h0, "R2 seq");
    step(1, 1'b1, 16'hFFFF, 26'h0, 32'h0, "R3 back one");
    step(1, 1'b1, 16'h0010, 26'h0, 32'h0, "R3 forward");
    step(1, 1'b1, 16'h8000, 26'h0, 32'h0, "R3 most negative");
    step(1, 1'b0, 16'h0100, 26'h0, 32'h0, "R4 not taken");
    step(4, 1'b0, 16'h0, 26'h0, 32'h0000_1000, "R8 regjump");
    step(2, 1'b1, 16'h0, 26'h3FF_FFFF, 32'h0, "R5 jump");
    step(3, 1'b0, 16'h0, 26'h000_0010, 32'h0, "R6 call crossing");
    step(3, 1'b0, 16'h0, 26'h000_0020, 32'h0, "R6 call repeat");
    step(4, 1'b0, 16'h0, 26'h0, 32'h0000_2003, "R9 misaligned");
    step(0, 1'b0, 16'h0, 26'h0, 32'h0, "R2 after misalign");
    step(4, 1'b1, 16'h0, 26'h0, 32'h0000_2002, "R9 misaligned b1");
    step(7, 1'b1, 16'h7FFF, 26'h3, 32'h0, "R2 code7");
    step(5, 1'b1, 16'h1234, 26'h1, 32'h4, "R2 code5");
    step(6, 1'b0, 16'h0, 26'h0, 32'h0, "R2 code6");
    step(4, 1'b0, 16'h0, 26'h0, 32'hFFFF_FFFC, "R8 top");
    step(0, 1'b0, 16'h0, 26'h0, 32'h0, "R2 wrap");
    step(2, 1'b0, 16'h0, 26'h0, 32'h0, "R5 zero field");

    for (int k = 0; k < 400; k++) begin
      int f;
      logic [31:0] r;
      f = int'($urandom_range(0, 7));
      r = $urandom();
      if ($urandom_range(0, 3) != 0) r[1:0] = 2'b00;
      step(f, 1'($urandom()), 16'($urandom()), 26'($urandom()), r, "R2-path random");
    end

    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset again pc", pc_o, RVEC);
    chk("R1 reset again link_we", 32'(link_we_o), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule